// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host register bus reach a slow, always-on register domain (real-time clock and power-control registers) that the host cannot address directly. The host programs a transfer through a small window of four 32-bit registers. It picks read or write and the byte lanes in a command register, loads the far-side address, and for writes the data word. It then writes 1 to the control register and polls that register until it reads zero. For a read, the far-side value is waiting in the data register at that point.

Toward the far domain the bridge holds a level request together with stable command fields until an acknowledge pulse comes back. The domain crossing is modelled as a fixed chain of `ACK_LAT` flop stages. The acknowledge and the returned read data both travel through this chain before the sequencer acts on them. The host selects a register by word index, which is the byte offset divided by four: control 0, command 1, address 2, data 3. Host reads are combinational on the selected index. `ACK_LAT` must be at least 1.

Top module: `rtc_window_bridge`

## Requirements
- R1: After reset the control, command, address and data registers all read zero, the bridge is idle and `far_req_o` is low.
- R2: The control register (word 0) reads bit 0 as the busy flag, with all other bits zero. The command register (word 1) keeps bits 7:0 of the written value and reads zero above them. The address (word 2) and data (word 3) registers keep and return all 32 bits.
- R3: A host write to the control register with bit 0 set, while idle, starts a transfer. Busy reads 1 from the next cycle until the transfer completes. A control write with bit 0 clear has no effect.
- R4: When command bit 0 is 0 the transfer is a read. `far_we_o` is 0, `far_be_o` is 0 whatever command bits 7:4 hold, and `far_addr_o` equals the address register. On completion the data register holds the far-side read data that arrived with the acknowledge.
- R5: When command bit 0 is 1 the transfer is a write. `far_we_o` is 1, `far_addr_o` and `far_wdata_o` equal the address and data registers, and the data register is left unchanged by completion. Command value 0xF1 writes all four lanes.
- R6: For a write, `far_be_o` equals command bits 7:4, one bit per byte lane, with bit 4 driving lane 0.
- R7: Host writes to the command, address or data registers while busy are ignored.
- R8: A start request while busy has no effect. The request stays high without a break and no second transfer follows completion.
- R9: The acknowledge is delayed by `ACK_LAT` stages. Busy and `far_req_o` clear on the cycle after the delayed acknowledge is seen, which is `ACK_LAT`+1 cycles after the cycle in which `far_ack_i` is high. The request fields stay stable while `far_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Host access strobe |
| reg_we_i | input | 1 | Host write when 1 |
| reg_word_i | input | 2 | Register word index (0 ctrl, 1 cmd, 2 addr, 3 data) |
| reg_wdata_i | input | DW | Host write data |
| reg_rdata_o | output | DW | Host read data for the selected word |
| far_req_o | output | 1 | Far-side request level |
| far_we_o | output | 1 | Far-side write select |
| far_be_o | output | 4 | Far-side byte-lane enables |
| far_addr_o | output | DW | Far-side register address |
| far_wdata_o | output | DW | Far-side write data |
| far_ack_i | input | 1 | Far-side acknowledge pulse |
| far_rdata_i | input | DW | Far-side read data, valid with the acknowledge |

## Verification
The bench targets the release point. If busy were cleared on the raw acknowledge, or one stage late, the exact-cycle check would see the flag drop early or linger. The read data is present on the far-side bus only during the acknowledge cycle. A bridge that sampled it at completion, or let a write capture it, would show the wrong word in the data register. Writes to the command, address and data registers and a second start are issued in the middle of a transfer. A bridge that accepted them would show changed register values or a request that breaks and restarts. A read command with lane bits set checks that lanes stay dark on reads, and a command write with bits above 7 set checks the command register width.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic [1:0] {
    RWB_CTRL = 2'd0,
    RWB_CMD  = 2'd1,
    RWB_ADDR = 2'd2,
    RWB_DATA = 2'd3
  } rwb_sel_e;

  localparam int unsigned CMD_W   = 8;
  localparam int unsigned WE_BIT  = 0;
  localparam int unsigned BE_LSB  = 4;
  localparam int unsigned LANES   = 4;
endpackage

// File: rtl/rwb_sync_delay.sv
module rwb_sync_delay #(
  parameter int unsigned W      = 33,
  parameter int unsigned STAGES = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rwb_host_regs.sv
module rwb_host_regs
  import rwb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       word_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             busy_i,
  input  logic             rd_done_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DW-1:0]    addr_o,
  output logic [DW-1:0]    data_o
);
  logic             wr_ok;
  logic [CMD_W-1:0] cmd_q;
  logic [DW-1:0]    addr_q, data_q;

  // register writes are only accepted while idle
  assign wr_ok   = req_i && we_i && !busy_i;
  assign start_o = wr_ok && (word_i == RWB_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (wr_ok) begin
      if (word_i == RWB_CMD)  cmd_q  <= wdata_i[CMD_W-1:0];
      if (word_i == RWB_ADDR) addr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             data_q <= '0;
    else if (rd_done_i)                      data_q <= rd_data_i;
    else if (wr_ok && word_i == RWB_DATA)    data_q <= wdata_i;
  end

  always_comb begin
    unique case (word_i)
      RWB_CTRL: rdata_o = {{(DW-1){1'b0}}, busy_i};
      RWB_CMD:  rdata_o = {{(DW-CMD_W){1'b0}}, cmd_q};
      RWB_ADDR: rdata_o = addr_q;
      default:  rdata_o = data_q;
    endcase
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  a_r7_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cmd_q));
  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(addr_q));
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_done_i) |=> $stable(data_q));
endmodule

// File: rtl/rwb_sequencer.sv
module rwb_sequencer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  input  logic is_read_i,
  output logic busy_o,
  output logic rd_done_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_q <= 1'b0;
    else if (start_i)           busy_q <= 1'b1;
    else if (busy_q && ack_i)   busy_q <= 1'b0;
  end

  assign busy_o    = busy_q;
  assign rd_done_o = busy_q && ack_i && is_read_i;

  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> busy_q);
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i) |=> !busy_q);
  a_r8_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
endmodule

// File: rtl/rtc_window_bridge.sv
module rtc_window_bridge
  import rwb_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned ACK_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_word_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             far_req_o,
  output logic             far_we_o,
  output logic [LANES-1:0] far_be_o,
  output logic [DW-1:0]    far_addr_o,
  output logic [DW-1:0]    far_wdata_o,
  input  logic             far_ack_i,
  input  logic [DW-1:0]    far_rdata_i
);
  localparam int unsigned XW = DW + 1;

  logic             start, busy, rd_done, ack_sync;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    addr, data, rdata_sync;
  logic [XW-1:0]    xing_q;

  rwb_host_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (reg_req_i),
    .we_i      (reg_we_i),
    .word_i    (reg_word_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .rd_done_i (rd_done),
    .rd_data_i (rdata_sync),
    .start_o   (start),
    .cmd_o     (cmd),
    .addr_o    (addr),
    .data_o    (data)
  );

  // fixed-latency model of the crossing; data rides with the ack
  rwb_sync_delay #(.W(XW), .STAGES(ACK_LAT)) u_xing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({far_ack_i, far_rdata_i}),
    .q_o    (xing_q)
  );
  assign {ack_sync, rdata_sync} = xing_q;

  rwb_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .ack_i     (ack_sync),
    .is_read_i (!cmd[WE_BIT]),
    .busy_o    (busy),
    .rd_done_o (rd_done)
  );

  assign far_req_o   = busy;
  assign far_we_o    = cmd[WE_BIT];
  assign far_be_o    = cmd[WE_BIT] ? cmd[BE_LSB +: LANES] : '0;
  assign far_addr_o  = addr;
  assign far_wdata_o = data;

  a_r9_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o |=> (!far_req_o || $stable({far_we_o, far_be_o, far_addr_o, far_wdata_o})));
  a_r4_read_no_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (far_req_o && !far_we_o) |-> (far_be_o == '0));
endmodule

// File: tb/rtc_window_bridge_tb.sv
`timescale 1ns/1ps
module rtc_window_bridge_tb;
  localparam int unsigned DW       = 32;
  localparam int unsigned ACK_LAT  = 3;
  localparam int unsigned FAR_WAIT = 2;
  localparam logic [31:0] JUNK     = 32'hBAD0_BAD0;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hF1, 32'h0000_0010, 32'h1234_5678, JUNK},
    '{8'h00, 32'h0000_0020, 32'h0F0F_0F0F, 32'hCAFE_F00D},
    '{8'h31, 32'h0000_0024, 32'hA5A5_5A5A, JUNK},
    '{8'hC1, 32'h0000_0028, 32'h0BAD_CAFE, JUNK},
    '{8'hF0, 32'h0000_002C, 32'h7777_7777, 32'h1357_9BDF},
    '{8'h00, 32'hFFFF_FFFC, 32'h0000_0000, 32'hFFFF_FFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0]    reg_word = 2'd0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic          far_req, far_we, far_ack = 1'b0;
  logic [3:0]    far_be;
  logic [DW-1:0] far_addr, far_wdata, far_rdata = '0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rtc_window_bridge #(.DW(DW), .ACK_LAT(ACK_LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_word_i(reg_word),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .far_req_o(far_req), .far_we_o(far_we), .far_be_o(far_be),
    .far_addr_o(far_addr), .far_wdata_o(far_wdata),
    .far_ack_i(far_ack), .far_rdata_i(far_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] w, output logic [31:0] d);
    reg_word = w;
    #1 d = reg_rdata;
  endtask

  // pulse ack with rd, then check busy timing exactly (R9)
  task automatic ack_and_finish(input logic [31:0] rd);
    logic [31:0] v;
    @(negedge clk);
    far_ack = 1'b1; far_rdata = rd;
    @(negedge clk);
    far_ack = 1'b0; far_rdata = JUNK ^ 32'hFFFF_0000;
    repeat (ACK_LAT - 1) @(negedge clk);
    host_rd(2'd0, v);
    chk("R9 busy still set at ACK_LAT", v, 32'h1);
    @(negedge clk);
    host_rd(2'd0, v);
    chk("R9 busy clear at ACK_LAT+1", v, 32'h0);
    chk("R9 request dropped", {31'b0, far_req}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      host_rd(w[1:0], v);
      chk("R1 register zero after reset", v, 32'h0);
    end
    chk("R1 request low after reset", {31'b0, far_req}, 32'h0);

    // R2 command width and full-width address/data
    host_wr(2'd1, 32'hFFFF_FFF1);
    host_rd(2'd1, v);
    chk("R2 command keeps bits 7:0 only", v, 32'h0000_00F1);
    host_wr(2'd2, 32'h8765_4321);
    host_rd(2'd2, v);
    chk("R2 address full width", v, 32'h8765_4321);

    // R3 control write with bit0 clear does nothing
    host_wr(2'd0, 32'hFFFF_FFFE);
    host_rd(2'd0, v);
    chk("R3 bit0 clear no start", v, 32'h0);
    chk("R3 bit0 clear no request", {31'b0, far_req}, 32'h0);

    // table walk: R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic        is_wr;
      logic [3:0]  exp_be;
      logic [31:0] exp_data;
      is_wr    = VECS[i].cmd[0];
      exp_be   = is_wr ? VECS[i].cmd[7:4] : 4'h0;
      exp_data = is_wr ? VECS[i].wdata : VECS[i].rdata;
      host_wr(2'd1, {24'h0, VECS[i].cmd});
      host_wr(2'd2, VECS[i].addr);
      host_wr(2'd3, VECS[i].wdata);
      host_wr(2'd0, 32'h1);
      host_rd(2'd0, v);
      chk("R3 busy after start", v, 32'h1);
      chk("R2 control reads only busy bit", v & 32'hFFFF_FFFE, 32'h0);
      repeat (FAR_WAIT) @(negedge clk);
      chk("R3 request held", {31'b0, far_req}, 32'h1);
      chk(is_wr ? "R5 write select" : "R4 read select", {31'b0, far_we}, {31'b0, is_wr});
      chk(is_wr ? "R6 lane enables" : "R4 no lanes on read", {28'b0, far_be}, {28'b0, exp_be});
      chk("R4 far address", far_addr, VECS[i].addr);
      if (is_wr) chk("R5 far write data", far_wdata, VECS[i].wdata);
      ack_and_finish(VECS[i].rdata);
      host_rd(2'd3, v);
      chk(is_wr ? "R5 data kept after write" : "R4 read data captured", v, exp_data);
    end

    // R7/R8 writes and restart during busy
    host_wr(2'd1, 32'h0000_0000);
    host_wr(2'd2, 32'h0000_0100);
    host_wr(2'd3, 32'h1111_1111);
    host_wr(2'd0, 32'h1);
    host_wr(2'd1, 32'h0000_00F1);
    chk("R8 request unbroken", {31'b0, far_req}, 32'h1);
    host_wr(2'd2, 32'h0000_0200);
    host_wr(2'd3, 32'h2222_2222);
    host_rd(2'd3, v);
    chk("R7 data write ignored while busy", v, 32'h1111_1111);
    host_wr(2'd0, 32'h1);
    chk("R8 request unbroken after restart", {31'b0, far_req}, 32'h1);
    host_rd(2'd1, v);
    chk("R7 command write ignored while busy", v, 32'h0);
    host_rd(2'd2, v);
    chk("R7 address write ignored while busy", v, 32'h0000_0100);
    chk("R7 far address unchanged", far_addr, 32'h0000_0100);
    ack_and_finish(32'h4242_4242);
    host_rd(2'd3, v);
    chk("R4 read result after busy writes", v, 32'h4242_4242);
    repeat (4) @(negedge clk);
    chk("R8 no second transfer", {31'b0, far_req}, 32'h0);
    host_rd(2'd0, v);
    chk("R8 idle after completion", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule